// File: doc/BRIEF.md
# Interrupt Cause Flag Controller

The block collects event pulses from a set of peripheral sources into sticky cause flags. Each source has an enable bit and a priority level. A flag that is pending, enabled and above the CPU's current level competes for a single interrupt request. The CPU side gets a request line, plus a vector and level pair that it latches a step later. If the source that raised the request is gone by the time the CPU latches, the vector reads as the illegal-interrupt number 11 and the level reads as 0.

Software reaches the block through a simple register port. Writes take effect on the clock edge and reads are combinational from the address. The register map is:

| Address | Contents |
|---|---|
| 0 | Cause flags |
| 1 | Enables |
| 2 | DMA request bits |
| 3 | DMA enable bits |
| 4 | Priority levels; source i uses bits [4i+2:4i], and the fourth bit of each slot reads 0 |

Two configuration inputs choose how writes act. One sets the style of the cause-flag register. The other sets the style of the two DMA bit registers. A hardware event always wins over a software clear of the same bit in the same cycle.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0, `vec_o` is 11, `lvl_o` is 0 and `dma_req_o` is 0.
- R2: A 1 on `evt_i[i]` sets cause flag i at the next clock edge.
- R3: With `flag_mode_i`=0, a write to address 0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: With `flag_mode_i`=1, a write to address 0 loads the data bits into the flags, so a 0 clears a flag and a 1 sets it.
- R5: When an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: A flag stays set while a request is outstanding until software clears it. Time alone never clears it.
- R7: With `dma_mode_i`=0, writes to addresses 2 and 3 only set bits (a 1 sets, a 0 has no effect). With `dma_mode_i`=1, the written value is loaded. `dma_req_o` is the AND of the DMA request and DMA enable bits.
- R8: Among the flags that are both set and enabled, the one with the highest level wins. A tie goes to the lowest index. `vec_o` is 16 plus the index of the winner and `lvl_o` is its level, both updated combinationally.
- R9: `irq_o` is 1 in the cycle after a winner exists whose level is strictly greater than `cpu_lvl_i`, and 0 otherwise. A level of 0 never requests.
- R10: When no such winner exists, `vec_o` is 11 and `lvl_o` is 0. This includes the cycle right after a clear while `irq_o` is still 1.
- R11: Enables and levels are plain read/write at addresses 1 and 4, with the field layout given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| flag_mode_i | input | 1 | Cause-flag write style: 0 = write 1 to clear, 1 = read/write |
| dma_mode_i | input | 1 | DMA bit write style: 0 = set only, 1 = read/write |
| evt_i | input | 8 | Per-source event pulses |
| cpu_lvl_i | input | 3 | Current CPU interrupt level |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector number of the winner, or 11 |
| lvl_o | output | 3 | Level of the winner, or 0 |
| dma_req_o | output | 8 | DMA requests |

## Verification
The assertions assume that the mode inputs stay steady around each write. They also assume that `addr_i` selects a mapped register whenever `wr_en_i` is high. They treat `cpu_lvl_i` as a level input that may change in any cycle. The stimulus changes the modes only on the falling edge, together with the write they govern. It writes only to addresses 0 to 4. It changes `cpu_lvl_i` on the falling edge and samples one step later. It drives each event pulse for exactly one cycle, so the set-wins case is reached on purpose by pairing a pulse with a clear of the same bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ILLEGAL_VEC = 11;

  typedef enum logic [2:0] {
    A_FLAG   = 3'd0,
    A_EN     = 3'd1,
    A_DMAREQ = 3'd2,
    A_DMAEN  = 3'd3,
    A_LVL    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             wr_i,
  input  logic             rw_mode_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] flag_o
);
  logic [N_SRC-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_i) begin
      if (rw_mode_i) flag_d = wdata_i;
      else           flag_d = flag_q & ~wdata_i;
    end
    flag_d = flag_d | evt_i;  // hardware set beats software clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_hw_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  p_w1c_keeps_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rw_mode_i) |=>
      ((flag_o & ~$past(wdata_i)) == (($past(flag_o) | $past(evt_i)) & ~$past(wdata_i))));

  p_persist_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/irq_dma_bits.sv
module irq_dma_bits #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rw_mode_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] bits_o
);
  logic [N_SRC-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else if (wr_i) bits_q <= rw_mode_i ? wdata_i : (bits_q | wdata_i);
  end

  assign bits_o = bits_q;

  p_set_only_no_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rw_mode_i) |=> ((bits_o & $past(bits_o)) == $past(bits_o)));

  p_rw_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rw_mode_i) |=> (bits_o == $past(wdata_i)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 16
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]       cur_lvl_i,
  output logic                   valid_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic [LVL_W-1:0]       lvl_o
);
  import irq_pkg::*;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             found;
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lower index on ties
      if (pend_i[i] && (!found || lvl_i[i*LVL_W +: LVL_W] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_i[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign valid_o = found && (best_lvl > cur_lvl_i);
  assign vec_o   = valid_o ? VEC_W'(VEC_BASE + int'(best_idx)) : VEC_W'(ILLEGAL_VEC);
  assign lvl_o   = valid_o ? best_lvl : '0;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned SLOT_W   = 4,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [N_SRC*SLOT_W-1:0]   wdata_i,
  output logic [N_SRC*SLOT_W-1:0]   rdata_o,
  input  logic                      flag_mode_i,
  input  logic                      dma_mode_i,
  input  logic [N_SRC-1:0]          evt_i,
  input  logic [LVL_W-1:0]          cpu_lvl_i,
  output logic                      irq_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [LVL_W-1:0]          lvl_o,
  output logic [N_SRC-1:0]          dma_req_o
);
  import irq_pkg::*;
  localparam int unsigned DATA_W = N_SRC * SLOT_W;

  logic [N_SRC-1:0]       flag, en_q, dreq, den;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic [DATA_W-1:0]      lvl_rd;
  logic                   wr_flag, wr_en_reg, wr_dreq, wr_den, wr_lvl;
  logic                   valid, irq_q;

  assign wr_flag   = wr_en_i && (addr_i == ADDR_W'(A_FLAG));
  assign wr_en_reg = wr_en_i && (addr_i == ADDR_W'(A_EN));
  assign wr_dreq   = wr_en_i && (addr_i == ADDR_W'(A_DMAREQ));
  assign wr_den    = wr_en_i && (addr_i == ADDR_W'(A_DMAEN));
  assign wr_lvl    = wr_en_i && (addr_i == ADDR_W'(A_LVL));

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk_i, .rst_ni, .evt_i,
    .wr_i(wr_flag), .rw_mode_i(flag_mode_i),
    .wdata_i(wdata_i[N_SRC-1:0]), .flag_o(flag)
  );

  irq_dma_bits #(.N_SRC(N_SRC)) u_dma_req (
    .clk_i, .rst_ni, .wr_i(wr_dreq), .rw_mode_i(dma_mode_i),
    .wdata_i(wdata_i[N_SRC-1:0]), .bits_o(dreq)
  );

  irq_dma_bits #(.N_SRC(N_SRC)) u_dma_en (
    .clk_i, .rst_ni, .wr_i(wr_den), .rw_mode_i(dma_mode_i),
    .wdata_i(wdata_i[N_SRC-1:0]), .bits_o(den)
  );

  assign dma_req_o = dreq & den;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_reg) en_q <= wdata_i[N_SRC-1:0];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lvl_q <= '0;
      else if (wr_lvl) lvl_q <= wdata_i[i*SLOT_W +: LVL_W];
    end
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
    assign lvl_rd[i*SLOT_W +: SLOT_W] = SLOT_W'(lvl_q);
  end

  irq_arbiter #(
    .N_SRC(N_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
  ) u_arb (
    .pend_i(flag & en_q), .lvl_i(lvl_flat), .cur_lvl_i(cpu_lvl_i),
    .valid_o(valid), .vec_o, .lvl_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= valid;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_FLAG):   rdata_o = DATA_W'(flag);
      ADDR_W'(A_EN):     rdata_o = DATA_W'(en_q);
      ADDR_W'(A_DMAREQ): rdata_o = DATA_W'(dreq);
      ADDR_W'(A_DMAEN):  rdata_o = DATA_W'(den);
      ADDR_W'(A_LVL):    rdata_o = lvl_rd;
      default:           rdata_o = '0;
    endcase
  end

  p_vec_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != VEC_W'(ILLEGAL_VEC)) |->
      ((flag & en_q) >> (vec_o - VEC_W'(VEC_BASE))) != '0 && lvl_o > cpu_lvl_i);

  p_illegal_lvl_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o == VEC_W'(ILLEGAL_VEC)) |-> (lvl_o == '0));

  p_irq_needs_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((flag & en_q) != '0));

  p_dma_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & ~den) == '0);
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        flag_mode_i = 1'b0;
  logic        dma_mode_i = 1'b0;
  logic [7:0]  evt_i = '0;
  logic [2:0]  cpu_lvl_i = '0;
  logic        irq_o;
  logic [7:0]  vec_o;
  logic [2:0]  lvl_o;
  logic [7:0]  dma_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  irq_flag_ctrl u_dut (.*);

  typedef struct packed {
    logic        fmode;
    logic        dmode;
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  evt;
    logic [2:0]  rd_addr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 3'd0, 32'h0,        8'h05, 3'd0, 32'h05,       8'd2},  // R2
    '{1'b0, 1'b0, 1'b1, 3'd0, 32'h01,       8'h00, 3'd0, 32'h04,       8'd3},  // R3
    '{1'b0, 1'b0, 1'b1, 3'd0, 32'h00,       8'h00, 3'd0, 32'h04,       8'd3},  // R3 zero no effect
    '{1'b0, 1'b0, 1'b1, 3'd0, 32'h04,       8'h04, 3'd0, 32'h04,       8'd5},  // R5 w1c vs event
    '{1'b1, 1'b0, 1'b1, 3'd0, 32'hF0,       8'h00, 3'd0, 32'hF0,       8'd4},  // R4
    '{1'b1, 1'b0, 1'b1, 3'd0, 32'h30,       8'h80, 3'd0, 32'hB0,       8'd5},  // R5 rw vs event
    '{1'b0, 1'b0, 1'b1, 3'd2, 32'h0F,       8'h00, 3'd2, 32'h0F,       8'd7},  // R7
    '{1'b0, 1'b0, 1'b1, 3'd2, 32'h30,       8'h00, 3'd2, 32'h3F,       8'd7},  // R7 set only
    '{1'b0, 1'b1, 1'b1, 3'd2, 32'h30,       8'h00, 3'd2, 32'h30,       8'd7},  // R7 rw
    '{1'b0, 1'b0, 1'b1, 3'd1, 32'hA5,       8'h00, 3'd1, 32'hA5,       8'd11}, // R11
    '{1'b0, 1'b0, 1'b1, 3'd4, 32'hFEDC3210, 8'h00, 3'd4, 32'h76543210, 8'd11}  // R11 slot pad
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic fm, input logic dm);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; flag_mode_i = fm; dma_mode_i = dm;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd_check("R1", 3'(a), 32'h0);
    check("R1", {31'b0, irq_o}, 32'h0);
    check("R1", {24'b0, vec_o}, 32'd11);
    check("R1", {29'b0, lvl_o}, 32'h0);
    check("R1", {24'b0, dma_req_o}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      wr_en_i = VECS[k].wr; addr_i = VECS[k].addr; wdata_i = VECS[k].wdata;
      evt_i = VECS[k].evt; flag_mode_i = VECS[k].fmode; dma_mode_i = VECS[k].dmode;
      @(negedge clk_i);
      wr_en_i = 1'b0; evt_i = '0;
      rd_check($sformatf("R%0d", VECS[k].req), VECS[k].rd_addr, VECS[k].exp);
    end

    // R7 output gating: dma req = 0x30, enable only bit 4
    wr(3'd3, 32'h10, 1'b0, 1'b0);
    #1 check("R7", {24'b0, dma_req_o}, 32'h10);

    // arbitration setup: src1 lvl3, src2 lvl5, src5 lvl5
    wr(3'd4, 32'h0050_0530, 1'b0, 1'b0);
    wr(3'd1, 32'hFF, 1'b0, 1'b0);
    cpu_lvl_i = 3'd0;
    wr(3'd0, 32'h26, 1'b1, 1'b0);
    #1;
    check("R8 tie vec", {24'b0, vec_o}, 32'd18);
    check("R8 lvl", {29'b0, lvl_o}, 32'd5);
    @(negedge clk_i); #1;
    check("R9 irq", {31'b0, irq_o}, 32'h1);

    // R9 cpu level blocks
    cpu_lvl_i = 3'd5;
    #1 check("R10 vec", {24'b0, vec_o}, 32'd11);
    @(negedge clk_i); #1;
    check("R9 masked", {31'b0, irq_o}, 32'h0);
    cpu_lvl_i = 3'd4;
    @(negedge clk_i); #1;
    check("R9 unmasked", {31'b0, irq_o}, 32'h1);

    // R6 flags persist while requesting
    repeat (3) @(negedge clk_i);
    rd_check("R6", 3'd0, 32'h26);
    check("R6 irq", {31'b0, irq_o}, 32'h1);

    // R8 disable src2 -> src5 wins
    wr(3'd1, 32'hFB, 1'b0, 1'b0);
    #1 check("R8 next", {24'b0, vec_o}, 32'd21);

    // R10 clear all while irq high
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 32'h0; flag_mode_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    check("R10 irq lag", {31'b0, irq_o}, 32'h1);
    check("R10 vec", {24'b0, vec_o}, 32'd11);
    check("R10 lvl", {29'b0, lvl_o}, 32'h0);
    @(negedge clk_i); #1;
    check("R9 drop", {31'b0, irq_o}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule